// File: doc/BRIEF.md
# CAN Fault Confinement Counter

This block tracks the fault state of a CAN node. It holds a 9-bit transmit error count and an 8-bit receive error count. It classifies the node as error-active, error-passive or bus-off. The protocol engine feeds it single-cycle event pulses: a transmit error, a receive error, a good transmitted frame, a good received frame, and a detected run of eleven consecutive recessive bits. The host reads the counts, the state, a warning status bit and two sticky interrupt flags. It clears each interrupt flag by pulsing a write-1-to-clear input.

Once the node is bus-off, the normal error bookkeeping stops. The receive counter is cleared and then counts recessive-run detections. When that count reaches 96, the warning flag raises. On the 128th detection the node recovers: both counters return to zero, the state goes back to error-active, and a recovery interrupt flag is set.

A synchronous soft reset input stands in for a standby-mode reset. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `can_fault_confine`

## Requirements
- R1: After reset, tec and rec read 0, fc_state reads 2'b00 (error-active), and warn_status, warn_irq and recov_irq read 0.
- R2: Outside bus-off, tx_err adds 8 to tec. tx_ok subtracts 1 from tec, with a floor at 0. When both pulse in the same cycle, tx_err takes priority.
- R3: Outside bus-off, rx_err adds 1 to rec, saturating at 255. rx_ok subtracts 1 from rec, with a floor at 0. When both pulse in the same cycle, rx_err takes priority.
- R4: fc_state is 2'b01 (error-passive) when the node is not bus-off and tec or rec is 128 or more. Otherwise, when not bus-off, it is 2'b00.
- R5: When tec exceeds 255 the node is bus-off, and fc_state is 2'b10. rec is cleared in the cycle bus-off is entered. While bus-off, tx_err, tx_ok, rx_err and rx_ok change neither counter.
- R6: While bus-off, each idle11 pulse adds 1 to rec. Outside bus-off, idle11 has no effect.
- R7: Outside bus-off, warn_status is 1 when tec or rec is 96 or more. While bus-off, warn_status is 1 when rec is 96 or more.
- R8: warn_irq is set at the same edge at which warn_status goes from 0 to 1. It stays set until clr_warn_irq is pulsed, and a set in the same cycle as a clear wins.
- R9: The 128th idle11 pulse in bus-off clears tec and rec, returns fc_state to 2'b00 and sets recov_irq. recov_irq stays set until clr_recov_irq is pulsed, and a set in the same cycle as a clear wins.
- R10: soft_rst clears both counters and both interrupt flags at the next edge. It takes priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| soft_rst | input | 1 | Synchronous clear (standby reset) |
| tx_err | input | 1 | Transmit error event pulse |
| tx_ok | input | 1 | Successful transmit event pulse |
| rx_err | input | 1 | Receive error event pulse |
| rx_ok | input | 1 | Successful receive event pulse |
| idle11 | input | 1 | Eleven-recessive-bit run detected |
| clr_warn_irq | input | 1 | Write 1 to clear warn_irq |
| clr_recov_irq | input | 1 | Write 1 to clear recov_irq |
| tec | output | 9 | Transmit error count |
| rec | output | 8 | Receive error count or recessive-run count |
| fc_state | output | 2 | 00 active, 01 passive, 10 bus-off |
| warn_status | output | 1 | Warning threshold status |
| warn_irq | output | 1 | Sticky warning interrupt flag |
| recov_irq | output | 1 | Sticky bus-off recovery interrupt flag |

## Verification
Every result is registered. A pulse sampled at one rising edge shows up in tec, rec, warn_irq and recov_irq right after that edge. fc_state and warn_status are decoded from those registers, so they follow in the same cycle. The bench drives each stimulus just after a falling edge and compares all six outputs against its arithmetic model at the following falling edge, one full cycle later. After a reset release, it waits out the two synchronizer stages before driving any event.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;
endpackage

// File: rtl/can_fc_tec.sv
module can_fc_tec #(
  parameter int TEC_W  = 9,
  parameter int TX_INC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             recover,
  output logic [TEC_W-1:0] tec_q,
  output logic [TEC_W-1:0] tec_nxt,
  output logic             busoff,
  output logic             busoff_enter
);
  localparam logic [TEC_W-1:0] INC = TEC_W'(TX_INC);
  localparam logic [TEC_W-1:0] ONE = TEC_W'(1);

  logic tec_en;

  assign busoff = tec_q[TEC_W-1];

  always_comb begin
    tec_nxt = tec_q;
    if (soft_rst || recover) begin
      tec_nxt = '0;
    end else if (!busoff) begin
      if (tx_err) begin
        tec_nxt = tec_q + INC;
      end else if (tx_ok && (tec_q != '0)) begin
        tec_nxt = tec_q - ONE;
      end
    end
  end

  assign busoff_enter = !busoff && tec_nxt[TEC_W-1];
  assign tec_en       = (tec_nxt != tec_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
    end else if (tec_en) begin
      tec_q <= tec_nxt;
    end
  end

  // R2: a lone good transmit lowers a nonzero count by one
  assert_txok_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busoff && tx_ok && !tx_err && !soft_rst && tec_q != '0)
    |=> (tec_q == $past(tec_q) - ONE));

  // R5: count frozen while bus-off unless recovering or cleared
  assert_busoff_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff && !recover && !soft_rst) |=> (tec_q == $past(tec_q)));
endmodule

// File: rtl/can_fc_rec.sv
module can_fc_rec #(
  parameter int REC_W       = 8,
  parameter int RECOVER_CNT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             rx_err,
  input  logic             rx_ok,
  input  logic             idle11,
  input  logic             busoff,
  input  logic             busoff_enter,
  output logic [REC_W-1:0] rec_q,
  output logic [REC_W-1:0] rec_nxt,
  output logic             recover
);
  localparam logic [REC_W-1:0] REC_MAX = {REC_W{1'b1}};
  localparam logic [REC_W-1:0] LAST    = REC_W'(RECOVER_CNT - 1);
  localparam logic [REC_W-1:0] ONE     = REC_W'(1);

  logic rec_en;

  assign recover = busoff && idle11 && (rec_q == LAST);

  always_comb begin
    rec_nxt = rec_q;
    if (soft_rst || recover || busoff_enter) begin
      rec_nxt = '0;
    end else if (busoff) begin
      if (idle11) begin
        rec_nxt = rec_q + ONE;
      end
    end else if (rx_err) begin
      if (rec_q != REC_MAX) begin
        rec_nxt = rec_q + ONE;
      end
    end else if (rx_ok && (rec_q != '0)) begin
      rec_nxt = rec_q - ONE;
    end
  end

  assign rec_en = (rec_nxt != rec_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
    end else if (rec_en) begin
      rec_q <= rec_nxt;
    end
  end

  // R6: recessive-run counting while bus-off
  assert_idle_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff && idle11 && !soft_rst && rec_q != LAST)
    |=> (rec_q == $past(rec_q) + ONE));

  // R3: saturation at the top of the receive count
  assert_rec_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busoff && !busoff_enter && !soft_rst && rx_err && rec_q == REC_MAX)
    |=> (rec_q == REC_MAX));
endmodule

// File: rtl/can_fc_flags.sv
module can_fc_flags #(
  parameter int TEC_W    = 9,
  parameter int REC_W    = 8,
  parameter int WARN_LIM = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [TEC_W-1:0] tec_q,
  input  logic [TEC_W-1:0] tec_nxt,
  input  logic [REC_W-1:0] rec_q,
  input  logic [REC_W-1:0] rec_nxt,
  input  logic             recover,
  input  logic             clr_warn,
  input  logic             clr_recov,
  output logic             warn_status,
  output logic             warn_irq,
  output logic             recov_irq
);
  localparam logic [TEC_W-1:0] WARN_T = TEC_W'(WARN_LIM);
  localparam logic [REC_W-1:0] WARN_R = REC_W'(WARN_LIM);

  function automatic logic warn_of(logic [TEC_W-1:0] t, logic [REC_W-1:0] r);
    if (t[TEC_W-1]) return (r >= WARN_R);
    return (t >= WARN_T) || (r >= WARN_R);
  endfunction

  logic warn_nx, warn_set;
  logic wirq_nxt, rirq_nxt, wirq_en, rirq_en;

  assign warn_status = warn_of(tec_q, rec_q);
  assign warn_nx     = warn_of(tec_nxt, rec_nxt);
  assign warn_set    = warn_nx && !warn_status && !soft_rst;

  always_comb begin
    wirq_nxt = warn_irq;
    rirq_nxt = recov_irq;
    if (soft_rst) begin
      wirq_nxt = 1'b0;
      rirq_nxt = 1'b0;
    end else begin
      if (warn_set)      wirq_nxt = 1'b1;
      else if (clr_warn) wirq_nxt = 1'b0;
      if (recover)        rirq_nxt = 1'b1;
      else if (clr_recov) rirq_nxt = 1'b0;
    end
  end

  assign wirq_en = (wirq_nxt != warn_irq);
  assign rirq_en = (rirq_nxt != recov_irq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_irq  <= 1'b0;
      recov_irq <= 1'b0;
    end else begin
      if (wirq_en) warn_irq  <= wirq_nxt;
      if (rirq_en) recov_irq <= rirq_nxt;
    end
  end

  // R8: a rising warning leaves the flag set
  assert_warn_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_set) |=> (warn_irq));

  // R9: recovery raises its flag, even against a clear
  assert_recov_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (recover && !soft_rst) |=> (recov_irq && tec_q == '0 && rec_q == '0));
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine #(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int TX_INC      = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 128,
  parameter int RECOVER_CNT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             tx_err,
  input  logic             tx_ok,
  input  logic             rx_err,
  input  logic             rx_ok,
  input  logic             idle11,
  input  logic             clr_warn_irq,
  input  logic             clr_recov_irq,
  output logic [TEC_W-1:0] tec,
  output logic [REC_W-1:0] rec,
  output logic [1:0]       fc_state,
  output logic             warn_status,
  output logic             warn_irq,
  output logic             recov_irq
);
  import can_fc_pkg::*;

  localparam logic [TEC_W-1:0] PASS_T = TEC_W'(PASSIVE_LIM);
  localparam logic [REC_W-1:0] PASS_R = REC_W'(PASSIVE_LIM);

  logic rst_meta, rst_sync;
  logic [TEC_W-1:0] tec_nxt;
  logic [REC_W-1:0] rec_nxt;
  logic busoff, busoff_enter, recover;
  fc_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  can_fc_tec #(.TEC_W(TEC_W), .TX_INC(TX_INC)) u_tec (
    .clk(clk), .rst_n(rst_sync), .soft_rst(soft_rst),
    .tx_err(tx_err), .tx_ok(tx_ok), .recover(recover),
    .tec_q(tec), .tec_nxt(tec_nxt),
    .busoff(busoff), .busoff_enter(busoff_enter)
  );

  can_fc_rec #(.REC_W(REC_W), .RECOVER_CNT(RECOVER_CNT)) u_rec (
    .clk(clk), .rst_n(rst_sync), .soft_rst(soft_rst),
    .rx_err(rx_err), .rx_ok(rx_ok), .idle11(idle11),
    .busoff(busoff), .busoff_enter(busoff_enter),
    .rec_q(rec), .rec_nxt(rec_nxt), .recover(recover)
  );

  can_fc_flags #(.TEC_W(TEC_W), .REC_W(REC_W), .WARN_LIM(WARN_LIM)) u_flags (
    .clk(clk), .rst_n(rst_sync), .soft_rst(soft_rst),
    .tec_q(tec), .tec_nxt(tec_nxt), .rec_q(rec), .rec_nxt(rec_nxt),
    .recover(recover), .clr_warn(clr_warn_irq), .clr_recov(clr_recov_irq),
    .warn_status(warn_status), .warn_irq(warn_irq), .recov_irq(recov_irq)
  );

  always_comb begin
    if (busoff)                              st = FC_BUSOFF;
    else if ((tec >= PASS_T) || (rec >= PASS_R)) st = FC_PASSIVE;
    else                                     st = FC_ACTIVE;
  end

  assign fc_state = st;

  // R10: soft reset empties everything at the next edge
  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_sync)
    (soft_rst) |=> (tec == '0 && rec == '0 && !warn_irq && !recov_irq));
endmodule

// File: tb/can_fault_confine_tb.sv
`timescale 1ns/1ps
module can_fault_confine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, tx_err = 0, tx_ok = 0, rx_err = 0, rx_ok = 0, idle11 = 0;
  logic clr_warn_irq = 0, clr_recov_irq = 0;
  logic [8:0] tec;
  logic [7:0] rec;
  logic [1:0] fc_state;
  logic warn_status, warn_irq, recov_irq;

  int checks = 0, fails = 0;
  int mt = 0, mr = 0;
  bit mwi = 0, mri = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_fault_confine u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .tx_err(tx_err), .tx_ok(tx_ok), .rx_err(rx_err), .rx_ok(rx_ok),
    .idle11(idle11), .clr_warn_irq(clr_warn_irq), .clr_recov_irq(clr_recov_irq),
    .tec(tec), .rec(rec), .fc_state(fc_state),
    .warn_status(warn_status), .warn_irq(warn_irq), .recov_irq(recov_irq)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit mwarn(int t, int r);
    if (t > 255) return r >= 96;
    return (t >= 96) || (r >= 96);
  endfunction

  function automatic int mstate(int t, int r);
    if (t > 255) return 2;
    if (t >= 128 || r >= 128) return 1;
    return 0;
  endfunction

  task automatic model_step(bit te, bit to, bit re, bit ro, bit id, bit cw, bit cr, bit sr);
    bit wold, wnew, rev;
    wold = mwarn(mt, mr);
    rev = 0;
    if (sr) begin
      mt = 0; mr = 0; mwi = 0; mri = 0;
      return;
    end
    if (mt > 255) begin
      if (id) begin
        if (mr == 127) begin mt = 0; mr = 0; rev = 1; end
        else mr++;
      end
    end else begin
      if (te) mt += 8;
      else if (to && mt > 0) mt--;
      if (re) begin
        if (mr < 255) mr++;
      end else if (ro && mr > 0) mr--;
      if (mt > 255) mr = 0;
    end
    wnew = mwarn(mt, mr);
    if (wnew && !wold) mwi = 1; else if (cw) mwi = 0;
    if (rev) mri = 1; else if (cr) mri = 0;
  endtask

  task automatic compare_all();
    chk(int'(tec) == mt, "R2 tec", int'(tec), mt);
    chk(int'(rec) == mr, "R3 rec", int'(rec), mr);
    chk(int'(fc_state) == mstate(mt, mr), "R4 state", int'(fc_state), mstate(mt, mr));
    chk(warn_status == mwarn(mt, mr), "R7 warn_status", int'(warn_status), int'(mwarn(mt, mr)));
    chk(warn_irq == mwi, "R8 warn_irq", int'(warn_irq), int'(mwi));
    chk(recov_irq == mri, "R9 recov_irq", int'(recov_irq), int'(mri));
  endtask

  task automatic cyc(bit te, bit to, bit re, bit ro, bit id, bit cw, bit cr, bit sr);
    tx_err = te; tx_ok = to; rx_err = re; rx_ok = ro; idle11 = id;
    clr_warn_irq = cw; clr_recov_irq = cr; soft_rst = sr;
    @(posedge clk);
    model_step(te, to, re, ro, id, cw, cr, sr);
    @(negedge clk);
    tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0; idle11 = 0;
    clr_warn_irq = 0; clr_recov_irq = 0; soft_rst = 0;
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    mt = 0; mr = 0; mwi = 0; mri = 0;
    repeat (2) @(negedge clk);
    chk(tec == 0 && rec == 0, "R1 counters in reset", int'(tec) + int'(rec), 0);
    chk(fc_state == 2'b00 && !warn_status && !warn_irq && !recov_irq,
        "R1 state and flags in reset", int'({fc_state, warn_status, warn_irq, recov_irq}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R3 sweep up through passive and saturation, warning on the way
    for (int i = 0; i < 260; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0);
    chk(rec == 255, "R3 saturates", int'(rec), 255);
    chk(fc_state == 2'b01, "R4 passive from rec", int'(fc_state), 1);
    cyc(0, 0, 1, 1, 0, 0, 0, 0);
    chk(rec == 255, "R3 error wins over ok", int'(rec), 255);
    for (int i = 0; i < 300; i++) cyc(0, 0, 0, 1, 0, 0, 0, 0);
    chk(rec == 0, "R3 floor at zero", int'(rec), 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    chk(!warn_irq, "R8 cleared by write", int'(warn_irq), 0);

    // R2 transmit sweep
    for (int i = 0; i < 12; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
    chk(tec == 96 && warn_status, "R7 tec at 96 warns", int'(tec), 96);
    cyc(1, 1, 0, 0, 0, 1, 0, 0);
    chk(tec == 104, "R2 error wins over ok", int'(tec), 104);
    chk(!warn_irq, "R8 clear with no new rise", int'(warn_irq), 0);
    for (int i = 0; i < 120; i++) cyc(0, 1, 0, 0, 0, 0, 0, 0);
    chk(tec == 0, "R2 floor at zero", int'(tec), 0);

    // R6 idle ignored outside bus-off
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0, 0, 0);
    chk(rec == 3, "R6 idle ignored when not bus-off", int'(rec), 3);

    // R5 enter bus-off
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 32; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0);
    chk(tec == 256 && fc_state == 2'b10, "R5 bus-off entered", int'(tec), 256);
    chk(rec == 0, "R5 rec cleared on entry", int'(rec), 0);
    cyc(1, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 1, 0, 0, 0, 0);
    chk(tec == 256 && rec == 0, "R5 events ignored in bus-off", int'(tec) + int'(rec), 256);

    // R6 / R7 / R8 / R9 recovery counting
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 96; i++) cyc(0, 0, 0, 0, 1, 0, 0, 0);
    chk(rec == 96 && warn_status && warn_irq, "R7 warn at 96 in bus-off", int'(rec), 96);
    for (int i = 0; i < 31; i++) cyc(0, 0, 0, 0, 1, 1, 0, 0);
    chk(rec == 127 && fc_state == 2'b10, "R6 still bus-off at 127", int'(rec), 127);
    cyc(0, 0, 0, 0, 1, 0, 1, 0);
    chk(recov_irq && tec == 0 && rec == 0 && fc_state == 2'b00,
        "R9 recovery with set over clear", int'(recov_irq), 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    chk(!recov_irq, "R9 cleared by write", int'(recov_irq), 0);

    // R10 soft reset priority
    for (int i = 0; i < 20; i++) cyc(1, 0, 1, 0, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 0, 0, 0, 1);
    chk(tec == 0 && rec == 0 && !warn_irq, "R10 soft reset wins", int'(tec) + int'(rec), 0);

    // mixed sweep in blocks of changing bias
    for (int blk = 0; blk < 16; blk++) begin
      for (int i = 0; i < 600; i++) begin
        int r;
        bit te, to, re, ro, id, cw, cr, sr;
        r  = int'($urandom % 1000);
        te = (blk % 2 == 1) ? ($urandom % 100 < 30) : ($urandom % 100 < 4);
        to = ($urandom % 100) < 20;
        re = (blk % 4 == 2) ? ($urandom % 100 < 45) : ($urandom % 100 < 10);
        ro = ($urandom % 100) < 20;
        id = ($urandom % 100) < 50;
        cw = ($urandom % 100) < 5;
        cr = ($urandom % 100) < 5;
        sr = (r < 2);
        cyc(te, to, re, ro, id, cw, cr, sr);
      end
      if (blk == 8) do_reset();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule